// File: doc/BRIEF.md
# Response Ring Status and Interrupt Unit

This unit sits between the codec link receiver and the DMA engine that copies codec responses into a 256-entry ring in system memory. Each incoming response first lands in a small internal FIFO. The DMA drains that FIFO through a ready/valid port. On each accepted response the unit advances the ring write slot and counts the response toward a programmable threshold.

The unit keeps an 8-bit status register with two sticky, write-1-to-clear bits:

- A response-interrupt flag, raised by whichever comes first:
  - the programmed number of responses has been written, or
  - a frame in which every serial data input reported an empty response slot.
- An overrun flag, raised when a response arrives while the FIFO is full. That response is dropped.

Both flags are recorded whatever the enables are. The single interrupt line is the OR of each flag gated by its own enable. A read-only size register reports the ring geometry.

Top module: `resp_ring_status`

## Requirements
- R1: Synchronous active-high reset clears both status flags, the interrupt line, the ring slot (to 0) and the response count, and empties the FIFO, so `dma_valid_o` is 0.
- R2: Responses leave on the DMA port in arrival order. `dma_valid_o` is high exactly while the FIFO holds an entry, and an entry is removed on a cycle where valid and ready are both high.
- R3: A response arriving while the FIFO already holds 4 entries is dropped and sets status bit 2 (overrun) on the next clock edge. The 4 held entries are unaffected.
- R4: The overrun flag is set even when the overrun enable is 0. In that case the interrupt line stays low.
- R5: With threshold N (1..255), status bit 0 is set on the edge that accepts the N-th response since the last trigger. The count then restarts from zero.
- R6: A threshold of 0 disables the count trigger: accepted responses never set bit 0.
- R7: A frame-end strobe with every bit of `slot_empty_i` high sets status bit 0 and restarts the response count. If any bit of `slot_empty_i` is low, the strobe has no effect.
- R8: A status write clears each of bits 2 and 0 that is written as 1, and leaves a bit written as 0 unchanged. Bits 7:3 and 1 always read 0.
- R9: A set event and a write-1 clear of the same bit on the same edge leave the bit set.
- R10: The interrupt line is a registered OR of (bit 2 AND overrun enable) and (bit 0 AND response enable). It rises on the edge the flag sets and falls on the edge that clears the flag.
- R11: `dma_slot_o` gives the ring slot of the entry at the DMA port. It increments by one on each accepted response and wraps from 255 to 0.
- R12: `size_o` reads constant 8'h42: capability 4'b0100 in bits 7:4, size code 2'b10 in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rsp_valid_i | input | 1 | A codec response is presented this cycle |
| rsp_data_i | input | 64 | Response word |
| frame_end_i | input | 1 | Strobe marking the end of a link frame |
| slot_empty_i | input | 3 | Per serial input: response slot of this frame was empty |
| dma_valid_o | output | 1 | FIFO holds a response for the DMA |
| dma_data_o | output | 64 | Oldest held response |
| dma_slot_o | output | 8 | Ring slot the offered response is written to |
| dma_ready_i | input | 1 | DMA accepts the offered response |
| resp_thresh_i | input | 8 | Response count threshold N; 0 disables the count trigger |
| ovr_ie_i | input | 1 | Overrun interrupt enable |
| rsp_ie_i | input | 1 | Response interrupt enable |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_i | input | 8 | Status write data, 1 bits clear flags |
| sts_o | output | 8 | Status register |
| size_o | output | 8 | Ring size register |
| irq_o | output | 1 | Level interrupt |

## Verification
Every result is due exactly one clock edge after the stimulus that causes it:

- the FIFO occupancy and DMA offer after a push or accept,
- the flags after an event or a status write,
- the interrupt line, which is registered from the flags' next value,
- the ring slot after an accept.

The bench changes inputs on falling edges, lets one rising edge pass, and samples on the following falling edge. So each check reads the value registered on the single edge that follows its stimulus. Same-edge collisions (set versus clear, overrun versus clear) are driven within one cycle so that they meet on one edge.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  localparam int STS_W     = 8;
  localparam int OVR_BIT   = 2;
  localparam int RSP_BIT   = 0;
  localparam logic [3:0] SIZE_CAP  = 4'b0100;
  localparam logic [1:0] SIZE_CODE = 2'b10;

  function automatic logic [STS_W-1:0] size_word();
    return {SIZE_CAP, 2'b00, SIZE_CODE};
  endfunction
endpackage

// File: rtl/rrs_fifo.sv
module rrs_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready,
  output logic         pop,
  output logic         overrun
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_a, rd_a;
  logic [AW:0]   cnt;
  logic          full, empty, push;

  assign full      = (cnt == (AW+1)'(DEPTH));
  assign empty     = (cnt == '0);
  assign push      = in_valid & ~full;
  assign pop       = out_ready & ~empty;
  assign overrun   = in_valid & full;
  assign out_valid = ~empty;
  assign out_data  = mem[rd_a];

  always_ff @(posedge clk) begin
    if (push) mem[wr_a] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_a <= '0;
      rd_a <= '0;
      cnt  <= '0;
    end else begin
      if (push) wr_a <= (wr_a == AW'(DEPTH-1)) ? '0 : wr_a + 1'b1;
      if (pop)  rd_a <= (rd_a == AW'(DEPTH-1)) ? '0 : rd_a + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= (AW+1)'(DEPTH));
  assert_drop_keeps_wr_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && full) |=> $stable(wr_a));
  assert_order_R2: assert property (@(posedge clk) disable iff (rst)
    (!out_ready) |=> $stable(rd_a));
endmodule

// File: rtl/rrs_counter.sv
module rrs_counter #(
  parameter int PTR_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pop,
  input  logic [CNT_W-1:0] thresh,
  input  logic             empty_all,
  output logic [PTR_W-1:0] wptr,
  output logic             fire
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_inc;
  logic             cnt_hit;

  assign cnt_inc = cnt + 1'b1;
  assign cnt_hit = pop && (thresh != '0) && (cnt_inc >= thresh);
  assign fire    = cnt_hit | empty_all;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      wptr <= '0;
    end else begin
      if (fire)     cnt <= '0;
      else if (pop) cnt <= cnt_inc;
      if (pop) wptr <= wptr + 1'b1;
    end
  end

  assert_wptr_step_R11: assert property (@(posedge clk) disable iff (rst)
    pop |=> wptr == $past(wptr) + 1'b1);
  assert_wptr_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !pop |=> $stable(wptr));
  assert_cnt_restart_R5: assert property (@(posedge clk) disable iff (rst)
    fire |=> cnt == '0);
endmodule

// File: rtl/rrs_status.sv
module rrs_status
  import rrs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ovr_evt,
  input  logic             rsp_evt,
  input  logic             wr,
  input  logic [STS_W-1:0] wdata,
  input  logic             ovr_ie,
  input  logic             rsp_ie,
  output logic [STS_W-1:0] sts,
  output logic             irq
);
  logic ovr_q, rsp_q, ovr_n, rsp_n;

  assign ovr_n = ovr_evt | (ovr_q & ~(wr & wdata[OVR_BIT]));
  assign rsp_n = rsp_evt | (rsp_q & ~(wr & wdata[RSP_BIT]));

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q <= 1'b0;
      rsp_q <= 1'b0;
      irq   <= 1'b0;
    end else begin
      ovr_q <= ovr_n;
      rsp_q <= rsp_n;
      irq   <= (ovr_n & ovr_ie) | (rsp_n & rsp_ie);
    end
  end

  always_comb begin
    sts          = '0;
    sts[OVR_BIT] = ovr_q;
    sts[RSP_BIT] = rsp_q;
  end

  assert_ovr_set_R3: assert property (@(posedge clk) disable iff (rst)
    ovr_evt |=> ovr_q);
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_evt |=> rsp_q);
  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (wr && wdata[RSP_BIT] && !rsp_evt) |=> !rsp_q);
  assert_keep_R8: assert property (@(posedge clk) disable iff (rst)
    (!wr && !ovr_evt) |=> ovr_q == $past(ovr_q));
  assert_irq_off_R10: assert property (@(posedge clk) disable iff (rst)
    (!ovr_q && !rsp_q) |-> !irq);
endmodule

// File: rtl/resp_ring_status.sv
module resp_ring_status
  import rrs_pkg::*;
#(
  parameter int RSP_W      = 64,
  parameter int FIFO_DEPTH = 4,
  parameter int NUM_SDI    = 3,
  parameter int PTR_W      = 8,
  parameter int CNT_W      = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rsp_valid_i,
  input  logic [RSP_W-1:0]   rsp_data_i,
  input  logic               frame_end_i,
  input  logic [NUM_SDI-1:0] slot_empty_i,
  output logic               dma_valid_o,
  output logic [RSP_W-1:0]   dma_data_o,
  output logic [PTR_W-1:0]   dma_slot_o,
  input  logic               dma_ready_i,
  input  logic [CNT_W-1:0]   resp_thresh_i,
  input  logic               ovr_ie_i,
  input  logic               rsp_ie_i,
  input  logic               sts_wr_i,
  input  logic [STS_W-1:0]   sts_wdata_i,
  output logic [STS_W-1:0]   sts_o,
  output logic [STS_W-1:0]   size_o,
  output logic               irq_o
);
  logic pop, overrun, fire, empty_all;

  assign empty_all = frame_end_i & (&slot_empty_i);
  assign size_o    = size_word();

  rrs_fifo #(.W(RSP_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (rsp_valid_i),
    .in_data   (rsp_data_i),
    .out_valid (dma_valid_o),
    .out_data  (dma_data_o),
    .out_ready (dma_ready_i),
    .pop       (pop),
    .overrun   (overrun)
  );

  rrs_counter #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .pop       (pop),
    .thresh    (resp_thresh_i),
    .empty_all (empty_all),
    .wptr      (dma_slot_o),
    .fire      (fire)
  );

  rrs_status u_sts (
    .clk     (clk),
    .rst     (rst),
    .ovr_evt (overrun),
    .rsp_evt (fire),
    .wr      (sts_wr_i),
    .wdata   (sts_wdata_i),
    .ovr_ie  (ovr_ie_i),
    .rsp_ie  (rsp_ie_i),
    .sts     (sts_o),
    .irq     (irq_o)
  );

  assert_no_count_when_off_R6: assert property (@(posedge clk) disable iff (rst)
    (resp_thresh_i == '0 && !empty_all && !sts_o[RSP_BIT]) |=> !sts_o[RSP_BIT]);
endmodule

// File: tb/test_resp_ring_status.sv
module test_resp_ring_status;
  logic        clk = 1'b0;
  logic        rst;
  logic        rsp_valid_i = 0;
  logic [63:0] rsp_data_i = '0;
  logic        frame_end_i = 0;
  logic [2:0]  slot_empty_i = '0;
  logic        dma_valid_o;
  logic [63:0] dma_data_o;
  logic [7:0]  dma_slot_o;
  logic        dma_ready_i = 0;
  logic [7:0]  resp_thresh_i = '0;
  logic        ovr_ie_i = 0, rsp_ie_i = 0, sts_wr_i = 0;
  logic [7:0]  sts_wdata_i = '0;
  logic [7:0]  sts_o, size_o;
  logic        irq_o;

  int total = 0, bad = 0;
  logic [7:0] exp_slot = '0;

  always #5 clk = ~clk;

  resp_ring_status i_resp_ring_status (.*);

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic push(logic [63:0] d);
    rsp_valid_i = 1; rsp_data_i = d; step(); rsp_valid_i = 0;
  endtask

  task automatic pop(string req, logic [63:0] d);
    chk(req, "dma_valid", dma_valid_o, 1);
    chk(req, "dma_data", dma_data_o, d);
    chk("R11", "slot", dma_slot_o, exp_slot);
    dma_ready_i = 1; step(); dma_ready_i = 0;
    exp_slot++;
  endtask

  task automatic wr_sts(logic [7:0] v);
    sts_wr_i = 1; sts_wdata_i = v; step(); sts_wr_i = 0; sts_wdata_i = '0;
  endtask

  task automatic frame(logic [2:0] e);
    frame_end_i = 1; slot_empty_i = e; step(); frame_end_i = 0; slot_empty_i = '0;
  endtask

  task automatic t_reset();
    rst = 1; step(); step(); rst = 0; step();
    chk("R1", "sts", sts_o, 0);
    chk("R1", "irq", irq_o, 0);
    chk("R1", "dma_valid", dma_valid_o, 0);
    chk("R1", "slot", dma_slot_o, 0);
    chk("R12", "size", size_o, 8'h42);
  endtask

  task automatic t_order();
    resp_thresh_i = 0;
    push(64'hA1); push(64'hB2); push(64'hC3);
    pop("R2", 64'hA1); pop("R2", 64'hB2); pop("R2", 64'hC3);
    chk("R2", "drained", dma_valid_o, 0);
    chk("R6", "no count trigger", sts_o[0], 0);
  endtask

  task automatic t_overrun_silent();
    ovr_ie_i = 0;
    for (int i = 0; i < 4; i++) push(64'h10 + i);
    chk("R3", "no ovr when just full", sts_o[2], 0);
    push(64'hDEAD);
    chk("R3", "ovr flag", sts_o[2], 1);
    chk("R4", "irq masked", irq_o, 0);
    for (int i = 0; i < 4; i++) pop("R3", 64'h10 + i);
    chk("R3", "extra dropped", dma_valid_o, 0);
    wr_sts(8'h04);
    chk("R8", "ovr cleared", sts_o, 0);
  endtask

  task automatic t_overrun_irq();
    ovr_ie_i = 1;
    for (int i = 0; i < 5; i++) push(64'h20 + i);
    chk("R10", "irq on ovr", irq_o, 1);
    wr_sts(8'hFB);
    chk("R8", "write 0 keeps", sts_o, 8'h04);
    chk("R8", "reserved zero", sts_o & 8'hFA, 0);
    // overrun plus clear on the same edge
    rsp_valid_i = 1; rsp_data_i = 64'h99; sts_wr_i = 1; sts_wdata_i = 8'h04; step();
    rsp_valid_i = 0; sts_wr_i = 0;
    chk("R9", "ovr set wins", sts_o[2], 1);
    wr_sts(8'h04);
    chk("R10", "irq drops", irq_o, 0);
    chk("R8", "cleared", sts_o, 0);
    for (int i = 0; i < 4; i++) pop("R3", 64'h20 + i);
    ovr_ie_i = 0;
  endtask

  task automatic t_empty();
    frame(3'b101);
    chk("R7", "partial empty ignored", sts_o[0], 0);
    frame(3'b111);
    chk("R7", "all empty sets", sts_o[0], 1);
    wr_sts(8'h01);
    chk("R8", "rsp cleared", sts_o[0], 0);
  endtask

  task automatic t_count();
    resp_thresh_i = 3; rsp_ie_i = 1;
    push(1); pop("R5", 1); push(2); pop("R5", 2);
    chk("R5", "below N", sts_o[0], 0);
    push(3); pop("R5", 3);
    chk("R5", "Nth sets", sts_o[0], 1);
    chk("R10", "irq rsp", irq_o, 1);
    wr_sts(8'h01);
    chk("R10", "irq off", irq_o, 0);
    push(4); pop("R5", 4); push(5); pop("R5", 5);
    chk("R5", "restart below N", sts_o[0], 0);
    frame(3'b111);
    chk("R7", "empty first", sts_o[0], 1);
    // empty-frame event colliding with a clear
    frame_end_i = 1; slot_empty_i = 3'b111; sts_wr_i = 1; sts_wdata_i = 8'h01; step();
    frame_end_i = 0; slot_empty_i = 0; sts_wr_i = 0;
    chk("R9", "rsp set wins", sts_o[0], 1);
    wr_sts(8'h01);
    push(6); pop("R7", 6); push(7); pop("R7", 7);
    chk("R7", "count restarted", sts_o[0], 0);
    push(8); pop("R5", 8);
    chk("R5", "fires after restart", sts_o[0], 1);
    wr_sts(8'h01);
    rsp_ie_i = 0;
  endtask

  task automatic t_wrap();
    resp_thresh_i = 0;
    while (exp_slot != 8'hFF) begin push(64'h5); pop("R11", 64'h5); end
    chk("R11", "at 255", dma_slot_o, 8'hFF);
    push(64'h6); pop("R11", 64'h6);
    chk("R11", "wrapped", dma_slot_o, 8'h00);
    chk("R6", "no trigger with N=0", sts_o[0], 0);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_order();
    t_overrun_silent();
    t_overrun_irq();
    t_empty();
    t_count();
    t_wrap();
    finish_run();
  end
endmodule